// File: doc/BRIEF.md
# Trace buffer watermark flow controller

This block owns the write pointer of an on-chip trace buffer. Each trace-write strobe moves the pointer forward by one 8-byte entry while tracing is enabled. The pointer wraps at a buffer size set by a parameter, which must be a power of two. Software reaches three 32-bit registers through a single-cycle register port: position, master control and flow. Reads are combinational. A write takes effect at the next clock edge.

The flow register holds a watermark address and two action bits. On every cycle the controller compares the watermark with the current pointer. On a match it can clear its own trace enable, which stops tracing. It can also set a sticky halt-request bit, and the halt-request output carries that bit to the processor only while the debug-enable input is high.

The trace RAM sits outside this block. It uses the pointer and enable outputs, both of which come straight from registers.

Register offsets are 0x0 for position, 0x4 for master control and 0x8 for flow. The master register holds trace enable in bit 0 and the halt request in bit 1. All its other bits read 0.

Top module: `trace_flow_ctrl`

## Requirements
- R1: After reset, all three registers read 0, the enable and pointer outputs are 0, and the halt-request output is 0.
- R2: The flow register (offset 0x8) stores the watermark in bits 31:3, auto-halt in bit 1 and auto-stop in bit 0. These bits read back as written. Bit 2 always reads 0, whatever value was written to it.
- R3: The position register (offset 0x0) shows the pointer in bits [log2(BUF_BYTES)-1:3]. All its other bits read 0. Each trace-write strobe adds 8 to the position value, but only while trace enable (master bit 0) is 1. Strobes that arrive while trace enable is 0 leave the position unchanged.
- R4: When the pointer is at the last entry of the buffer, the next accepted strobe takes it back to 0.
- R5: If auto-stop is 1 and the watermark equals the pointer, master bit 0 reads 0 from the next cycle. A strobe in the match cycle is still accepted.
- R6: If auto-halt is 1 and the watermark equals the pointer, master bit 1 reads 1 from the next cycle. It stays 1 after the pointer moves on. It clears only when software writes 0 to it while no auto-halt match is present.
- R7: The halt-request output equals master bit 1 ANDed with the debug-enable input, in the same cycle.
- R8: If both action bits are 1 and a match occurs, enable clears and halt sets at the same clock edge.
- R9: In a cycle with an active auto-stop match, a software write to the master register leaves enable at 0. In a cycle with an active auto-halt match, the write leaves halt at 1.
- R10: A write to the position register loads the pointer from write-data bits [log2(BUF_BYTES)-1:3]. This write wins over a strobe in the same cycle.
- R11: A watermark with any bit set above the buffer's range never matches, so neither action occurs.
- R12: With both action bits 0, a match changes neither enable nor halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| trace_wr_i | input | 1 | Trace-write strobe; one per entry written |
| dbg_en_i | input | 1 | Debug enable; gates the halt request |
| dbg_halt_req_o | output | 1 | Halt request to the processor |
| trace_en_o | output | 1 | Trace enable (master bit 0) |
| trace_ptr_o | output | log2(BUF_BYTES)-3 | Current entry index |

## Verification
Two things can land on the master register at the same clock edge: an automatic change from a watermark match and a software write. The bench parks the pointer on the watermark with both action bits set. In that same cycle it writes enable=1 and halt=0, and then reads the master register on the following cycle, where it expects enable 0 and halt 1. The random phase uses small watermarks, so matches are frequent. It mixes those matches with master writes and strobes. Every read is compared with a bench model that applies the stated priorities.

// File: rtl/trace_flow_pkg.sv
package trace_flow_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 4;
  localparam int MARK_LSB = 3;
  localparam int MARK_W   = REG_W - MARK_LSB;

  localparam logic [REG_AW-1:0] OFF_POS    = 4'h0;
  localparam logic [REG_AW-1:0] OFF_MASTER = 4'h4;
  localparam logic [REG_AW-1:0] OFF_FLOW   = 4'h8;

  localparam int MST_EN_BIT    = 0;
  localparam int MST_HALT_BIT  = 1;
  localparam int FLOW_STOP_BIT = 0;
  localparam int FLOW_HALT_BIT = 1;

  typedef struct packed {
    logic [MARK_W-1:0] mark;
    logic              auto_halt;
    logic              auto_stop;
  } flow_cfg_t;
endpackage

// File: rtl/trace_ptr_unit.sv
module trace_ptr_unit #(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (adv_i)  ptr_q <= ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/trace_wm_cmp.sv
module trace_wm_cmp
  import trace_flow_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [MARK_W-1:0] mark_i,
  output logic              hit_o
);
  logic low_eq;
  logic high_zero;

  assign low_eq = (mark_i[PTR_W-1:0] == ptr_i);

  generate
    if (PTR_W < MARK_W) begin : g_high
      assign high_zero = (mark_i[MARK_W-1:PTR_W] == '0);
    end else begin : g_full
      assign high_zero = 1'b1;
    end
  endgenerate

  assign hit_o = low_eq && high_zero;
endmodule

// File: rtl/trace_flow_reg.sv
module trace_flow_reg
  import trace_flow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output flow_cfg_t        cfg_o
);
  flow_cfg_t cfg_q;
  logic      unused_rsvd;

  assign unused_rsvd = wdata_i[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q.mark      <= wdata_i[REG_W-1:MARK_LSB];
      cfg_q.auto_halt <= wdata_i[FLOW_HALT_BIT];
      cfg_q.auto_stop <= wdata_i[FLOW_STOP_BIT];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/trace_master_ctl.sv
module trace_master_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_en_i,
  input  logic wr_halt_i,
  input  logic stop_i,
  input  logic halt_set_i,
  output logic en_o,
  output logic halt_o
);
  logic en_q, halt_q;
  logic en_d, halt_d;

  always_comb begin
    en_d   = en_q;
    halt_d = halt_q;
    if (wr_i) begin
      en_d   = wr_en_i;
      halt_d = wr_halt_i;
    end
    if (stop_i)     en_d   = 1'b0;
    if (halt_set_i) halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      halt_q <= halt_d;
    end
  end

  assign en_o   = en_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/trace_flow_ctrl.sv
module trace_flow_ctrl
  import trace_flow_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  localparam int PTR_W = $clog2(BUF_BYTES) - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              trace_wr_i,
  input  logic              dbg_en_i,
  output logic              dbg_halt_req_o,
  output logic              trace_en_o,
  output logic [PTR_W-1:0]  trace_ptr_o
);
  logic      we_pos, we_master, we_flow;
  logic      en_q, halt_q, wm_hit;
  logic      stop_fire, halt_fire;
  logic [PTR_W-1:0] ptr_q;
  flow_cfg_t cfg;

  assign we_pos    = reg_we_i && (reg_addr_i == OFF_POS);
  assign we_master = reg_we_i && (reg_addr_i == OFF_MASTER);
  assign we_flow   = reg_we_i && (reg_addr_i == OFF_FLOW);

  trace_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (trace_wr_i && en_q),
    .load_i     (we_pos),
    .load_val_i (reg_wdata_i[PTR_W+2:3]),
    .ptr_o      (ptr_q)
  );

  trace_flow_reg u_flow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (we_flow),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg)
  );

  trace_wm_cmp #(.PTR_W(PTR_W)) u_cmp (
    .ptr_i  (ptr_q),
    .mark_i (cfg.mark),
    .hit_o  (wm_hit)
  );

  assign stop_fire = wm_hit && cfg.auto_stop;
  assign halt_fire = wm_hit && cfg.auto_halt;

  trace_master_ctl u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (we_master),
    .wr_en_i    (reg_wdata_i[MST_EN_BIT]),
    .wr_halt_i  (reg_wdata_i[MST_HALT_BIT]),
    .stop_i     (stop_fire),
    .halt_set_i (halt_fire),
    .en_o       (en_q),
    .halt_o     (halt_q)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_POS:    reg_rdata_o[PTR_W+2:3] = ptr_q;
      OFF_MASTER: begin
        reg_rdata_o[MST_EN_BIT]   = en_q;
        reg_rdata_o[MST_HALT_BIT] = halt_q;
      end
      OFF_FLOW: begin
        reg_rdata_o[REG_W-1:MARK_LSB] = cfg.mark;
        reg_rdata_o[FLOW_HALT_BIT]    = cfg.auto_halt;
        reg_rdata_o[FLOW_STOP_BIT]    = cfg.auto_stop;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign dbg_halt_req_o = halt_q && dbg_en_i;
  assign trace_en_o     = en_q;
  assign trace_ptr_o    = ptr_q;
endmodule

// File: rtl/trace_flow_ctrl_chk.sv
module trace_flow_ctrl_chk
  import trace_flow_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              trace_wr_i,
  input logic              dbg_en_i,
  input logic              dbg_halt_req_o,
  input logic              trace_en_o,
  input logic [PTR_W-1:0]  trace_ptr_o,
  input logic              halt_q,
  input logic              wm_hit,
  input logic              auto_stop,
  input logic              auto_halt
);
  logic wr_pos, wr_mst;
  assign wr_pos = reg_we_i && (reg_addr_i == OFF_POS);
  assign wr_mst = reg_we_i && (reg_addr_i == OFF_MASTER);

  AST_HALT_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt_req_o |-> dbg_en_i); // R7
  AST_HALT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_q |-> !dbg_halt_req_o); // R7
  AST_STOP_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_hit && auto_stop) |=> !trace_en_o); // R5
  AST_HALT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_hit && auto_halt) |=> halt_q); // R6
  AST_BOTH_ACTIONS: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_hit && auto_halt && auto_stop) |=> (halt_q && !trace_en_o)); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_mst) |=> halt_q); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en_o && !wr_pos) |=> $stable(trace_ptr_o)); // R3
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en_o && trace_wr_i && !wr_pos) |=>
      (trace_ptr_o == PTR_W'($past(trace_ptr_o) + 1'b1))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == OFF_FLOW) |-> !reg_rdata_o[2]); // R2
endmodule

bind trace_flow_ctrl trace_flow_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .reg_rdata_o    (reg_rdata_o),
  .trace_wr_i     (trace_wr_i),
  .dbg_en_i       (dbg_en_i),
  .dbg_halt_req_o (dbg_halt_req_o),
  .trace_en_o     (trace_en_o),
  .trace_ptr_o    (trace_ptr_o),
  .halt_q         (halt_q),
  .wm_hit         (wm_hit),
  .auto_stop      (cfg.auto_stop),
  .auto_halt      (cfg.auto_halt)
);

// File: tb/trace_flow_ctrl_test.sv
module trace_flow_ctrl_test;
  localparam int BUF = 256;
  localparam int PW  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trace_wr = 1'b0;
  logic        dbg_en = 1'b0;
  logic        dbg_halt_req;
  logic        trace_en;
  logic [PW-1:0] trace_ptr;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [PW-1:0] m_ptr;
  logic          m_en, m_halt, m_as, m_ah;
  logic [28:0]   m_wm;

  always #5 clk = ~clk;

  trace_flow_ctrl #(.BUF_BYTES(BUF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .trace_wr_i(trace_wr),
    .dbg_en_i(dbg_en), .dbg_halt_req_o(dbg_halt_req), .trace_en_o(trace_en),
    .trace_ptr_o(trace_ptr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    logic [31:0] r = '0;
    case (a)
      4'h0: r[PW+2:3] = m_ptr;
      4'h4: r[1:0] = {m_halt, m_en};
      4'h8: r = {m_wm, 1'b0, m_ah, m_as};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_step(input logic we, input logic [3:0] a, input logic [31:0] d, input logic s);
    logic hit = (m_wm == {24'b0, m_ptr});
    logic [PW-1:0] np = m_ptr;
    logic ne = m_en, nh = m_halt;
    if (we && a == 4'h0) np = d[PW+2:3];
    else if (m_en && s) np = m_ptr + 1'b1;
    if (we && a == 4'h4) begin ne = d[0]; nh = d[1]; end
    if (hit && m_as) ne = 1'b0;
    if (hit && m_ah) nh = 1'b1;
    if (we && a == 4'h8) begin m_wm = d[31:3]; m_ah = d[1]; m_as = d[0]; end
    m_ptr = np; m_en = ne; m_halt = nh;
  endtask

  // op: 0 idle, 1 write, 2 read
  task automatic cyc(input int op, input logic [3:0] a, input logic [31:0] d,
                     input logic s, input logic g, input string tag);
    @(negedge clk);
    reg_we = (op == 1); reg_addr = a; reg_wdata = d; trace_wr = s; dbg_en = g;
    #1;
    if (op == 2) check(tag, reg_rdata, model_read(a));
    check("R7", {31'b0, dbg_halt_req}, {31'b0, m_halt & g});
    model_step(op == 1, a, d, s);
  endtask

  task automatic strobes(input int n, input logic g);
    for (int i = 0; i < n; i++) cyc(0, 4'h0, '0, 1'b1, g, "R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_ptr = '0; m_en = 0; m_halt = 0; m_as = 0; m_ah = 0; m_wm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); reg_addr = 4'(k * 4); #1;
      check("R1", reg_rdata, 32'h0);
    end
    check("R1", {30'b0, trace_en, dbg_halt_req}, 32'h0);

    // R2 layout and reserved bit; R11 out-of-range mark never hits; R4 wrap
    cyc(1, 4'h8, 32'hFFFF_FFFF, 0, 1, "R2");
    cyc(2, 4'h8, '0, 0, 1, "R2");
    check("R2", model_read(4'h8), 32'hFFFF_FFFB);
    cyc(1, 4'h4, 32'h1, 0, 1, "R11");
    strobes(40, 1);
    cyc(2, 4'h4, '0, 0, 1, "R11");
    cyc(2, 4'h0, '0, 0, 1, "R4");
    check("R4", model_read(4'h0), 32'h40);

    // R3 strobes ignored while disabled
    cyc(1, 4'h4, 32'h0, 0, 1, "R3");
    strobes(5, 1);
    cyc(2, 4'h0, '0, 0, 1, "R3");

    // R12 match without actions
    cyc(1, 4'h8, 32'd10 << 3, 0, 1, "R12");
    cyc(1, 4'h0, 32'd10 << 3, 0, 1, "R12");
    cyc(1, 4'h4, 32'h1, 0, 1, "R12");
    cyc(0, 4'h0, '0, 0, 1, "R12");
    cyc(2, 4'h4, '0, 0, 1, "R12");
    check("R12", model_read(4'h4), 32'h1);

    // R5 auto-stop
    cyc(1, 4'h0, 32'h0, 0, 1, "R5");
    cyc(1, 4'h8, (32'd3 << 3) | 32'h1, 0, 1, "R5");
    strobes(5, 1);
    cyc(2, 4'h4, '0, 0, 1, "R5");
    check("R5", model_read(4'h4), 32'h0);
    cyc(2, 4'h0, '0, 1, 1, "R5");
    check("R5", model_read(4'h0), 32'd4 << 3);

    // R6 auto-halt, sticky; R7 gating
    cyc(1, 4'h0, 32'h0, 0, 0, "R6");
    cyc(1, 4'h8, (32'd2 << 3) | 32'h2, 0, 0, "R6");
    cyc(1, 4'h4, 32'h1, 0, 0, "R6");
    strobes(2, 0);
    cyc(2, 4'h4, '0, 0, 0, "R6");
    check("R6", model_read(4'h4), 32'h3);
    cyc(0, 4'h0, '0, 0, 1, "R7");
    strobes(3, 1);
    cyc(2, 4'h4, '0, 0, 1, "R6");
    cyc(1, 4'h4, 32'h1, 0, 1, "R6");
    cyc(2, 4'h4, '0, 0, 1, "R6");
    check("R6", model_read(4'h4), 32'h1);

    // R8 and R9: write master in the cycle a double match is active
    cyc(1, 4'h4, 32'h0, 0, 1, "R9");
    cyc(1, 4'h8, (32'd5 << 3) | 32'h3, 0, 1, "R9");
    cyc(1, 4'h0, 32'd5 << 3, 0, 1, "R9");
    cyc(1, 4'h4, 32'h1, 0, 1, "R9");
    cyc(2, 4'h4, '0, 0, 1, "R8");
    check("R9", model_read(4'h4), 32'h2);

    // R10 load beats strobe
    cyc(1, 4'h8, 32'hFFFF_FFF8, 0, 1, "R10");
    cyc(1, 4'h4, 32'h1, 0, 1, "R10");
    cyc(1, 4'h0, 32'd20 << 3, 1, 1, "R10");
    cyc(2, 4'h0, '0, 0, 1, "R10");
    check("R10", model_read(4'h0), 32'd20 << 3);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [3:0] a = 4'($urandom_range(0, 3) * 4);
      logic [31:0] d = $urandom();
      int op = (r < 45) ? 2 : (r < 70) ? 1 : 0;
      if (a == 4'h8) d[31:3] = 29'($urandom_range(0, 39));
      if (a == 4'h4 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      cyc(op, a, d, ($urandom_range(0, 9) < 6), 1'($urandom_range(0, 1)),
          (a == 4'h4) ? "R9" : (a == 4'h0) ? "R3" : "R2");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule